// File: doc/BRIEF.md
# Packed Saturating Rounding Multiply-Accumulate-High Lane Unit

This block is a packed signed-integer datapath for a vector unit. It multiplies every element of a first 128-bit operand by a single element picked from a second 128-bit operand. That picked element is copied to all lanes. Each full-precision product is doubled and then added to, or subtracted from, the matching accumulator element, which sits in the upper half of a double-width value. A half-LSB rounding constant is added, and the high half is kept. Saturation to the signed element range happens only at this last step.

The control fields set how the operands are read:
- An element-size code selects 16-bit or 32-bit lanes.
- A width select chooses 64-bit or 128-bit data.
- A scalar flag limits the work to lane 0.
- A subtract flag chooses the accumulate direction.
- Three index bits (called H, L and M here) select the broadcast element. For 32-bit elements they also supply the top bit of the second-operand register number.

A reserved size code gives an illegal-encoding indication and no result. The unit has a one-cycle registered interface. It keeps a sticky saturation flag that only reset clears.

Top module: `satmac_high_unit`

## Requirements
- R1: With size code 2'b01 (16-bit lanes) and the subtract flag low, each active lane gives clamp16(floor((acc·2^16 + 2·a·b + 2^15) / 2^16)). Here a, acc and b are signed, and lane k occupies bits [16k+15:16k].
- R2: With the subtract flag high, the doubled product is subtracted rather than added. Everything else is unchanged.
- R3: With size code 2'b10 (32-bit lanes), each active lane gives clamp32(floor((acc·2^32 ± 2·a·b + 2^31) / 2^32)). Lane k occupies bits [32k+31:32k].
- R4: The broadcast element b is lane {H,L,M} (0..7) of the second operand for 16-bit lanes, and lane {H,L} (0..3) for 32-bit lanes.
- R5: src2_reg_msb equals M for size code 2'b10. It is 0 for size code 2'b01 and for reserved codes.
- R6: In vector mode the width select gives 128 data bits when high and 64 when low. In scalar mode only lane 0 is computed. All result bits above the active data are 0.
- R7: The product and the doubling are never clamped. Only the final value is clamped. For example, a = b = most-negative with a most-positive accumulator gives the most-positive value. Subtracting the same product from a most-negative accumulator gives the most-negative value.
- R8: sat_sticky goes to 1 when any active lane clamps. Clamping in an inactive lane does not set it. Only reset clears it.
- R9: Size codes 2'b00 and 2'b11 set illegal_enc, give a zero result, and leave sat_sticky unchanged.
- R10: out_valid is high exactly one cycle after in_valid. Result and flags update only for a valid input and hold otherwise.
- R11: A synchronous active-high reset clears out_valid, result, illegal_enc, src2_reg_msb and sat_sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| op_a | input | 128 | Multiplicand elements |
| op_b | input | 128 | Word holding the broadcast element |
| op_acc | input | 128 | Accumulator elements |
| size_code | input | 2 | 01 = 16-bit, 10 = 32-bit, others reserved |
| wide_sel | input | 1 | 1 = 128-bit data, 0 = 64-bit (vector mode) |
| scalar_mode | input | 1 | Process lane 0 only |
| sub_mode | input | 1 | Subtract doubled product |
| idx_h | input | 1 | Index bit H |
| idx_l | input | 1 | Index bit L |
| idx_m | input | 1 | Index bit M |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Lane results |
| sat_sticky | output | 1 | Cumulative saturation flag |
| illegal_enc | output | 1 | Reserved size code seen |
| src2_reg_msb | output | 1 | Top bit of the second-operand register number |

## Verification
The bench targets the case where most-negative times most-negative meets an extreme accumulator, in both directions. A design that clamps the doubled product early, or drops a bit of the intermediate, returns a wrapped or off-by-one value there instead of the clamp limit.

It also places a clamping value in a lane that lies outside the narrow width. A design that ORs saturation over all lanes would then raise the sticky flag wrongly.

Reserved size codes are sent with inputs that would otherwise clamp, to catch a sticky update on an illegal request. Each index position and the 64-bit and scalar forms are checked, to expose a wrong index bit order or upper bits that are not cleared.

// File: rtl/satmac_pkg.sv
package satmac_pkg;

  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_RSV_HI = 2'b11
  } size_code_e;

  function automatic logic code_legal(input logic [1:0] code);
    return (code == SZ_HALF) || (code == SZ_WORD);
  endfunction

  // element index for 16-bit lanes: H is the most significant bit
  function automatic logic [2:0] half_index(input logic h, input logic l, input logic m);
    return {h, l, m};
  endfunction

  // element index for 32-bit lanes: M is not part of it
  function automatic logic [1:0] word_index(input logic h, input logic l);
    return {h, l};
  endfunction

endpackage

// File: rtl/satmac_bcast_sel.sv
module satmac_bcast_sel
  import satmac_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int H_ESIZE = 16,
  parameter int W_ESIZE = 32
) (
  input  logic [DATA_W-1:0]  op_b,
  input  logic [1:0]         size_code,
  input  logic               idx_h,
  input  logic               idx_l,
  input  logic               idx_m,
  output logic [H_ESIZE-1:0] b_half,
  output logic [W_ESIZE-1:0] b_word,
  output logic               reg_msb
);

  logic [2:0] hidx;
  logic [1:0] widx;

  assign hidx = half_index(idx_h, idx_l, idx_m);
  assign widx = word_index(idx_h, idx_l);

  assign b_half  = op_b[int'(hidx)*H_ESIZE +: H_ESIZE];
  assign b_word  = op_b[int'(widx)*W_ESIZE +: W_ESIZE];
  assign reg_msb = (size_code == SZ_WORD) ? idx_m : 1'b0;

endmodule

// File: rtl/satmac_lane.sv
module satmac_lane #(
  parameter int ESIZE = 16
) (
  input  logic [ESIZE-1:0] a_elem,
  input  logic [ESIZE-1:0] b_elem,
  input  logic [ESIZE-1:0] acc_elem,
  input  logic             sub_mode,
  output logic [ESIZE-1:0] res_elem,
  output logic             sat
);

  localparam int WW = 2*ESIZE + 4;
  localparam logic signed [WW-1:0] RND  = WW'(1) <<< (ESIZE-1);
  localparam logic signed [WW-1:0] MAXV = (WW'(1) <<< (ESIZE-1)) - WW'(1);
  localparam logic signed [WW-1:0] MINV = -(WW'(1) <<< (ESIZE-1));

  function automatic logic signed [WW-1:0] sext(input logic [ESIZE-1:0] v);
    return {{(WW-ESIZE){v[ESIZE-1]}}, v};
  endfunction

  // full-precision intermediate: acc in the upper half, +/- 2ab, + half LSB
  function automatic logic signed [WW-1:0] wide_sum(input logic [ESIZE-1:0] a,
                                                   input logic [ESIZE-1:0] b,
                                                   input logic [ESIZE-1:0] c,
                                                   input logic sub);
    logic signed [WW-1:0] dbl;
    logic signed [WW-1:0] up;
    dbl = (sext(a) * sext(b)) <<< 1;
    up  = sext(c) <<< ESIZE;
    return sub ? (up - dbl + RND) : (up + dbl + RND);
  endfunction

  logic signed [WW-1:0] hi_part;
  logic                 over_hi;
  logic                 over_lo;

  assign hi_part = wide_sum(a_elem, b_elem, acc_elem, sub_mode) >>> ESIZE;
  assign over_hi = hi_part > MAXV;
  assign over_lo = hi_part < MINV;
  assign sat     = over_hi | over_lo;

  always_comb begin
    if (over_hi)      res_elem = MAXV[ESIZE-1:0];
    else if (over_lo) res_elem = MINV[ESIZE-1:0];
    else              res_elem = hi_part[ESIZE-1:0];
  end

endmodule

// File: rtl/satmac_lane_array.sv
module satmac_lane_array #(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64,
  parameter int ESIZE    = 16
) (
  input  logic [DATA_W-1:0] a_word,
  input  logic [DATA_W-1:0] acc_word,
  input  logic [ESIZE-1:0]  b_elem,
  input  logic              sub_mode,
  input  logic              wide_sel,
  input  logic              scalar_mode,
  output logic [DATA_W-1:0] res_word,
  output logic              sat_any
);

  localparam int NL   = DATA_W / ESIZE;
  localparam int NL_N = NARROW_W / ESIZE;

  logic [NL-1:0] lane_sat;
  logic [NL-1:0] lane_on;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [ESIZE-1:0] r;
    satmac_lane #(.ESIZE(ESIZE)) u_lane (
      .a_elem  (a_word[i*ESIZE +: ESIZE]),
      .b_elem  (b_elem),
      .acc_elem(acc_word[i*ESIZE +: ESIZE]),
      .sub_mode(sub_mode),
      .res_elem(r),
      .sat     (lane_sat[i])
    );
    assign lane_on[i] = scalar_mode ? (i == 0) : (wide_sel || (i < NL_N));
    assign res_word[i*ESIZE +: ESIZE] = lane_on[i] ? r : '0;
  end

  assign sat_any = |(lane_sat & lane_on);

endmodule

// File: rtl/satmac_high_unit.sv
module satmac_high_unit
  import satmac_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64,
  parameter int H_ESIZE  = 16,
  parameter int W_ESIZE  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_acc,
  input  logic [1:0]        size_code,
  input  logic              wide_sel,
  input  logic              scalar_mode,
  input  logic              sub_mode,
  input  logic              idx_h,
  input  logic              idx_l,
  input  logic              idx_m,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              sat_sticky,
  output logic              illegal_enc,
  output logic              src2_reg_msb
);

  logic [H_ESIZE-1:0] b_half;
  logic [W_ESIZE-1:0] b_word;
  logic               reg_msb_w;
  logic [DATA_W-1:0]  res_half;
  logic [DATA_W-1:0]  res_word;
  logic               sat_half;
  logic               sat_word;
  logic               legal_w;
  logic               sat_event;
  logic [DATA_W-1:0]  res_next;

  satmac_bcast_sel #(.DATA_W(DATA_W), .H_ESIZE(H_ESIZE), .W_ESIZE(W_ESIZE)) u_sel (
    .op_b     (op_b),
    .size_code(size_code),
    .idx_h    (idx_h),
    .idx_l    (idx_l),
    .idx_m    (idx_m),
    .b_half   (b_half),
    .b_word   (b_word),
    .reg_msb  (reg_msb_w)
  );

  satmac_lane_array #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .ESIZE(H_ESIZE)) u_half (
    .a_word     (op_a),
    .acc_word   (op_acc),
    .b_elem     (b_half),
    .sub_mode   (sub_mode),
    .wide_sel   (wide_sel),
    .scalar_mode(scalar_mode),
    .res_word   (res_half),
    .sat_any    (sat_half)
  );

  satmac_lane_array #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .ESIZE(W_ESIZE)) u_word (
    .a_word     (op_a),
    .acc_word   (op_acc),
    .b_elem     (b_word),
    .sub_mode   (sub_mode),
    .wide_sel   (wide_sel),
    .scalar_mode(scalar_mode),
    .res_word   (res_word),
    .sat_any    (sat_word)
  );

  assign legal_w   = code_legal(size_code);
  assign sat_event = legal_w && ((size_code == SZ_HALF) ? sat_half : sat_word);

  always_comb begin
    if (!legal_w)                 res_next = '0;
    else if (size_code == SZ_HALF) res_next = res_half;
    else                          res_next = res_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      sat_sticky   <= 1'b0;
      illegal_enc  <= 1'b0;
      src2_reg_msb <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= res_next;
        illegal_enc  <= !legal_w;
        src2_reg_msb <= reg_msb_w;
        if (sat_event) sat_sticky <= 1'b1;
      end
    end
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sat_sticky |=> sat_sticky);

  // R8
  sat_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_event) |=> sat_sticky);

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal_enc) |-> (result == '0));

  // R9
  illegal_keeps_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal_w) |=> (sat_sticky == $past(sat_sticky)));

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel) |=> (result[DATA_W-1:NARROW_W] == '0));

  // R6
  scalar_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar_mode && size_code == SZ_WORD) |=> (result[DATA_W-1:W_ESIZE] == '0));

  // R5
  half_msb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code != SZ_WORD) |=> !src2_reg_msb);

endmodule

// File: tb/tb_satmac_high_unit.sv
`timescale 1ns/1ps
module tb_satmac_high_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0, op_acc = '0;
  logic [1:0]   size_code = 2'b01;
  logic         wide_sel = 1'b1, scalar_mode = 1'b0, sub_mode = 1'b0;
  logic         idx_h = 1'b0, idx_l = 1'b0, idx_m = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_sticky, illegal_enc, src2_reg_msb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_sticky = 1'b0;
  logic [127:0] last_res = '0;

  typedef struct {
    logic [127:0] res;
    bit           sticky;
    bit           ill;
    bit           msb;
    string        req;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  satmac_high_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_acc(op_acc),
    .size_code(size_code), .wide_sel(wide_sel), .scalar_mode(scalar_mode),
    .sub_mode(sub_mode), .idx_h(idx_h), .idx_l(idx_l), .idx_m(idx_m),
    .out_valid(out_valid), .result(result), .sat_sticky(sat_sticky),
    .illegal_enc(illegal_enc), .src2_reg_msb(src2_reg_msb)
  );

  // signed element k of width esz
  function automatic longint elem(logic [127:0] w, int esz, int k);
    logic [127:0] v;
    longint u;
    v = (w >> (k*esz)) & ((128'd1 << esz) - 128'd1);
    u = longint'(v[63:0]);
    if (u >= (64'sd1 <<< (esz-1))) u = u - (64'sd1 <<< esz);
    return u;
  endfunction

  // reference lane: multiply by a power of two, floor by arithmetic shift, clamp
  function automatic logic [31:0] ref_lane(int esz, longint a, longint b, longint c,
                                           bit sub, output bit sat);
    logic signed [127:0] t, p, q, lim;
    t = c;
    t = t * (128'sd1 <<< esz);
    p = a;
    p = p * b;
    t = sub ? (t - 2*p) : (t + 2*p);
    t = t + (128'sd1 <<< (esz-1));
    q = t >>> esz;
    lim = 128'sd1 <<< (esz-1);
    sat = 1'b0;
    if (q >= lim) begin q = lim - 1; sat = 1'b1; end
    else if (q < -lim) begin q = -lim; sat = 1'b1; end
    return q[31:0];
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(logic [1:0] code, bit wide, bit scal, bit sub, bit h, bit l, bit m,
                      logic [127:0] a, logic [127:0] b, logic [127:0] c, string req);
    exp_t e;
    int esz, idx, nl;
    longint be;
    bit s;
    logic [31:0] r;
    @(negedge clk);
    op_a = a; op_b = b; op_acc = c; size_code = code; wide_sel = wide;
    scalar_mode = scal; sub_mode = sub; idx_h = h; idx_l = l; idx_m = m;
    in_valid = 1'b1;
    e.res = '0; e.ill = 1'b0; e.msb = 1'b0; e.req = req;
    if (code == 2'b01 || code == 2'b10) begin
      esz = (code == 2'b01) ? 16 : 32;
      idx = (code == 2'b01) ? (h*4 + l*2 + m) : (h*2 + l);
      be  = elem(b, esz, idx);
      nl  = scal ? 1 : ((wide ? 128 : 64) / esz);
      for (int k = 0; k < nl; k++) begin
        r = ref_lane(esz, elem(a, esz, k), be, elem(c, esz, k), sub, s);
        e.res = e.res | ((128'(r) & ((128'd1 << esz) - 128'd1)) << (k*esz));
        if (s) exp_sticky = 1'b1;
      end
      e.msb = (code == 2'b10) ? m : 1'b0;
    end else begin
      e.ill = 1'b1;
    end
    e.sticky = exp_sticky;
    last_res = e.res;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard whenever a result is presented
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual=out_valid expected=no output");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " result"}, result, e.res);
        chk({e.req, " R8 sticky"}, 128'(sat_sticky), 128'(e.sticky));
        chk({e.req, " R9 illegal"}, 128'(illegal_enc), 128'(e.ill));
        chk({e.req, " R5 msb"}, 128'(src2_reg_msb), 128'(e.msb));
      end
    end
  end

  initial begin
    #(4*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [127:0] A1 = 128'h0123_fedc_0456_f000_1111_eeee_7000_9000;
  localparam logic [127:0] B1 = 128'h0001_2000_e000_0300_fd00_4000_0022_c000;
  localparam logic [127:0] C1 = 128'h1000_8001_7ffe_0000_ffff_0123_4000_c000;

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", 128'(out_valid), 128'd0);
    chk("R11 result", result, '0);
    chk("R11 sticky", 128'(sat_sticky), 128'd0);
    rst = 1'b0;

    // R1 R4: 16-bit add, various index positions
    send(2'b01, 1, 0, 0, 1, 0, 1, 128'h0010_0020_0030_0040_0050_0060_0070_0080,
         128'h0000_0400_0000_0000_0000_0000_0000_0000, 128'h0001_0002_0003_0004_fff0_fff1_fff2_fff3, "R1 R4 idx5");
    send(2'b01, 1, 0, 0, 0, 1, 1, 128'h0100_0200_ff00_fe00_0300_0400_0500_0600,
         128'h0000_0000_0000_0000_0800_0000_0000_0000, 128'h0000_0000_0000_0000_0000_0000_0000_0000, "R1 R4 idx3");
    send(2'b01, 1, 0, 0, 0, 0, 0, 128'h00ff_0100_0080_007f_ff01_ff00_ff80_ff81,
         128'h0000_0000_0000_0000_0000_0000_0000_0100, 128'h0010_0010_0010_0010_0010_0010_0010_0010, "R1 R4 idx0 rounding");
    // R2: subtract
    send(2'b01, 1, 0, 1, 0, 1, 0, 128'h0100_0200_ff00_fe00_0300_0400_0500_0600,
         128'h0000_0000_0000_0000_0000_0800_0000_0000, 128'h0100_0100_0100_0100_0100_0100_0100_0100, "R2 idx2");
    // R3 R5: 32-bit add idx {H,L}=3, M=1
    send(2'b10, 1, 0, 0, 1, 1, 1, 128'h0001_0000_fffe_0000_1234_5678_edcb_a988,
         128'h0004_0000_0000_0000_0000_0000_0000_0000, 128'h0000_0010_ffff_fff0_0001_0000_0000_0000, "R3 R5 idx3 M1");
    // R2 R3 R5: 32-bit subtract idx 0, M=0
    send(2'b10, 1, 0, 1, 0, 0, 0, 128'h0001_0000_fffe_0000_1234_5678_edcb_a988,
         128'h0000_0000_0000_0000_0000_0000_0020_0000, 128'h0000_0010_ffff_fff0_0001_0000_0000_0000, "R2 R3 R5 idx0");
    // R6: narrow and scalar forms with nonzero upper data
    send(2'b01, 0, 0, 0, 1, 1, 0, A1, 128'h0000_0300_0000_0000_0000_0000_0000_0000, C1, "R6 narrow16");
    send(2'b10, 0, 0, 0, 0, 1, 0, A1, 128'h0000_0000_0000_0000_0100_0000_0000_0000, C1, "R6 narrow32");
    send(2'b01, 1, 1, 0, 0, 0, 1, A1, 128'h0000_0000_0000_0000_0000_0000_0200_0000, C1, "R6 scalar16");
    send(2'b10, 1, 1, 1, 0, 0, 1, A1, 128'h0000_0000_0000_0000_0000_0000_0100_0000, C1, "R6 scalar32");
    // R8: clamping only in an inactive lane (lane 6 of a narrow 16-bit op)
    send(2'b01, 0, 0, 0, 0, 0, 0, 128'h0000_8000_0000_0000_0001_0002_0003_0004,
         128'h0000_0000_0000_0000_0000_0000_0000_8000, 128'h0000_7fff_0000_0000_0000_0000_0000_0000, "R8 inactive lane");
    // R9: reserved codes with inputs that would clamp
    send(2'b00, 1, 0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h7fff}}, "R9 code00");
    send(2'b11, 1, 0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h7fff}}, "R9 code11");
    idle(2);
    chk("R8 R9 sticky clear", 128'(sat_sticky), 128'd0);
    chk("R9 illegal result", result, '0);

    // R7: extreme corners
    send(2'b01, 1, 0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h7fff}}, "R7 pos16");
    send(2'b01, 1, 0, 1, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, "R7 neg16");
    send(2'b10, 1, 0, 0, 0, 1, 0, {4{32'h8000_0000}}, {4{32'h8000_0000}}, {4{32'h7fff_ffff}}, "R7 pos32");
    send(2'b10, 1, 0, 1, 1, 1, 0, {4{32'h8000_0000}}, {4{32'h8000_0000}}, {4{32'h8000_0000}}, "R7 neg32");
    send(2'b01, 1, 0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h0000}}, "R7 product only");
    send(2'b01, 1, 0, 0, 0, 0, 0, {8{16'h8000}}, {8{16'h8000}}, {8{16'hc000}}, "R7 no clamp");
    // R8: sticky holds after a quiet op
    send(2'b01, 1, 0, 0, 0, 0, 0, 128'h1, 128'h1, 128'h0, "R8 hold");
    idle(2);
    chk("R7 R8 sticky set", 128'(sat_sticky), 128'd1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [1:0] code;
      code = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      send(code, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, "R1 R2 R3 R4 R6 random");
    end
    idle(3);
    // R10: idle -> no valid, result held
    chk("R10 idle valid", 128'(out_valid), 128'd0);
    chk("R10 hold result", result, last_res);
    chk("R10 queue drained", 128'(sb.size()), 128'd0);

    // R11: reset mid-run clears sticky
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R11 sticky after reset", 128'(sat_sticky), 128'd0);
    chk("R11 result after reset", result, '0);
    chk("R11 valid after reset", 128'(out_valid), 128'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule